// File: doc/BRIEF.md
# Integer ALU with Selectable Overflow Trap

This is the 32-bit combinational arithmetic and logic unit for the execute stage of a small load/store processor. It takes two operands, a 5-bit shift amount and a 4-bit operation select. It returns a 32-bit result, a zero flag and an overflow flag. Immediate operands arrive already sign-extended on the second operand. The zero flag feeds the equal and not-equal branch decision. The overflow flag is handed to the exception logic outside this block.

Add, add-immediate and subtract each come in two forms that share one adder. The signed form reports two's-complement overflow. The unsigned form gives the identical 32-bit sum or difference, but it never reports overflow and simply wraps modulo 2^32. Logical shifts by a 0 to 31 bit immediate amount complete the operation set.

Top module: `alu_core`

## Requirements
- R1: With op_sel 4'h0 (add) or 4'h1 (add-immediate), result is opnd_a + opnd_b modulo 2^32.
- R2: With op_sel 4'h0 or 4'h1, ovf_flag is 1 exactly when both operands have the same sign bit and the sign bit of the result differs from it.
- R3: With op_sel 4'h3 (unsigned add), 4'h4 (unsigned add-immediate) or 4'h5 (unsigned subtract), ovf_flag is always 0. The result wraps modulo 2^32, so 0xFFFFFFFF + 3 gives 2.
- R4: With op_sel 4'h2 (subtract) or 4'h5, result is opnd_a - opnd_b modulo 2^32.
- R5: With op_sel 4'h2, ovf_flag is 1 exactly when the operand sign bits differ and the result sign bit differs from that of opnd_a.
- R6: With op_sel 4'h6 (shift left), result is opnd_a moved shamt places toward the MSB. Bits shifted out are lost and the vacated low bits are 0, so 0x00000002 shifted by 2 gives 0x00000008. ovf_flag is 0.
- R7: With op_sel 4'h7 (shift right), result is opnd_a moved shamt places toward the LSB, with the vacated high bits 0. ovf_flag is 0.
- R8: A shamt of 0 under either shift passes opnd_a through unchanged. opnd_b has no effect on either shift.
- R9: zero_flag is 1 exactly when all 32 result bits are 0, whatever the operation and whatever ovf_flag is.
- R10: Any op_sel from 4'h8 to 4'hF gives result 0 and ovf_flag 0, so zero_flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand or sign-extended immediate |
| shamt | input | 5 | Shift distance, 0 to 31 |
| op_sel | input | 4 | Operation select (encodings in R1 to R10) |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow from add, add-immediate or subtract |

## Verification
The hardest cases to produce are the ones where the two flags interact. One is a signed add that overflows into an all-zero result: 0x80000000 + 0x80000000 must raise both flags together. The other is a subtract whose operands differ in sign, where only a carefully chosen pair actually overflows. The directed stimulus sends each of these operand pairs through the signed opcode and then the unsigned opcode, so that only the overflow flag may differ between the two runs. The shifts are driven at distances 0, 1 and 31, with a nonzero second operand applied at the same time, to confirm that the second operand is ignored.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int DATA_W  = 32;
    parameter int SHAMT_W = $clog2(DATA_W);
    parameter int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'h0,
        OP_ADDI  = 4'h1,
        OP_SUB   = 4'h2,
        OP_ADDU  = 4'h3,
        OP_ADDIU = 4'h4,
        OP_SUBU  = 4'h5,
        OP_SLL   = 4'h6,
        OP_SRL   = 4'h7
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_SHIFT = 2'd1,
        UNIT_NONE  = 2'd2
    } alu_unit_e;

    typedef struct packed {
        alu_unit_e unit;
        logic      subtract;
        logic      trap_ovf;
        logic      shift_left;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] code);
        alu_ctrl_t c;
        c = '{unit: UNIT_NONE, subtract: 1'b0, trap_ovf: 1'b0, shift_left: 1'b0};
        case (code)
            OP_ADD, OP_ADDI: begin
                c.unit     = UNIT_ARITH;
                c.trap_ovf = 1'b1;
            end
            OP_SUB: begin
                c.unit     = UNIT_ARITH;
                c.subtract = 1'b1;
                c.trap_ovf = 1'b1;
            end
            OP_ADDU, OP_ADDIU: c.unit = UNIT_ARITH;
            OP_SUBU: begin
                c.unit     = UNIT_ARITH;
                c.subtract = 1'b1;
            end
            OP_SLL: begin
                c.unit       = UNIT_SHIFT;
                c.shift_left = 1'b1;
            end
            OP_SRL: c.unit = UNIT_SHIFT;
            default: c.unit = UNIT_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         ovf_raw
);

    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W-1:0] cin_vec;

    assign b_eff   = subtract ? ~b : b;
    assign cin_vec = {{(W-1){1'b0}}, subtract};
    assign sum     = a + b_eff + cin_vec;

    // Same-sign inputs to the adder with a sign flip at the output
    assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

    // Cross-check against wide signed arithmetic (R2, R5)
    logic signed [W:0] wide_ref;
    always_comb begin
        wide_ref = subtract ? ($signed({a[MSB], a}) - $signed({b[MSB], b}))
                            : ($signed({a[MSB], a}) + $signed({b[MSB], b}));
        a_r2_r5_ovf_matches_wide: assert (ovf_raw == (wide_ref[W] != wide_ref[MSB]))
            else $error("raw overflow disagrees with wide result");
        a_r1_r4_sum_low_bits: assert (sum == wide_ref[MSB:0])
            else $error("sum disagrees with wide result");
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int SH_W = SHAMT_W
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    input  logic            go_left,
    output logic [W-1:0]    dout
);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] core_in;
    logic [W-1:0] stage [0:SH_W];

    // A left shift is a right shift of the bit-reversed word
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = din[W-1-i];
        assign rev_out[i] = stage[SH_W][W-1-i];
    end

    assign core_in  = go_left ? rev_in : din;
    assign stage[0] = core_in;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        assign stage[s+1] = amt[s] ? {{DIST{1'b0}}, stage[s][W-1:DIST]} : stage[s];
    end

    assign dout = go_left ? rev_out : stage[SH_W];

    always_comb begin
        a_r6_r7_shift_value: assert (dout == (go_left ? (din << amt) : (din >> amt)))
            else $error("shifter output mismatch");
        a_r8_zero_distance: assert ((amt != '0) || (dout == din))
            else $error("zero shift altered operand");
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect
    import alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int CHUNK = 8
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);

    localparam int NCHUNK = (W + CHUNK - 1) / CHUNK;
    localparam int PAD_W  = NCHUNK * CHUNK;

    logic [PAD_W-1:0]  padded;
    logic [NCHUNK-1:0] any_set;

    assign padded = {{(PAD_W-W){1'b0}}, value};

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        assign any_set[c] = |padded[c*CHUNK +: CHUNK];
    end

    assign is_zero = ~|any_set;

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int SH_W = SHAMT_W
) (
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [SH_W-1:0] shamt,
    input  logic [OP_W-1:0] op_sel,
    output logic [W-1:0]    result,
    output logic            zero_flag,
    output logic            ovf_flag
);

    alu_ctrl_t    ctrl;
    logic [W-1:0] arith_out;
    logic         arith_ovf;
    logic [W-1:0] shift_out;

    assign ctrl = decode_op(op_sel);

    alu_addsub #(.W(W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .subtract (ctrl.subtract),
        .sum      (arith_out),
        .ovf_raw  (arith_ovf)
    );

    alu_shift #(.W(W), .SH_W(SH_W)) u_shift (
        .din     (opnd_a),
        .amt     (shamt),
        .go_left (ctrl.shift_left),
        .dout    (shift_out)
    );

    always_comb begin
        case (ctrl.unit)
            UNIT_ARITH: begin
                result   = arith_out;
                ovf_flag = arith_ovf & ctrl.trap_ovf;
            end
            UNIT_SHIFT: begin
                result   = shift_out;
                ovf_flag = 1'b0;
            end
            default: begin
                result   = '0;
                ovf_flag = 1'b0;
            end
        endcase
    end

    alu_zero_detect #(.W(W)) u_zero (
        .value   (result),
        .is_zero (zero_flag)
    );

    always_comb begin
        a_r3_no_overflow: assert (!((op_sel == OP_ADDU) || (op_sel == OP_ADDIU) ||
                                    (op_sel == OP_SUBU)) || !ovf_flag)
            else $error("unsigned operation raised overflow");
        a_r9_zero_flag: assert (zero_flag == (result == '0))
            else $error("zero flag disagrees with result");
        a_r10_unused_op: assert (!op_sel[OP_W-1] || ((result == '0) && !ovf_flag))
            else $error("unused opcode produced output");
    end

endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  shamt;
    logic [3:0]  op_sel;
    logic [31:0] result;
    logic        zero_flag, ovf_flag;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #10 clk = ~clk;   // 50 MHz

    alu_core dut_i (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shamt     (shamt),
        .op_sel    (op_sel),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    always @(posedge clk) begin
        if (rst) cycles <= 0;
        else begin
            cycles <= cycles + 1;
            if (cycles > 20000) begin
                failures = failures + 1;
                checks   = checks + 1;
                $display("FAIL watchdog: run hung, actual cycles=%0d expected<20000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    // Apply one operation and compare with the expected triple
    task automatic apply_and_check(input string tag, input logic [3:0] op,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [4:0] sh, input logic [31:0] exp_res,
                                   input logic exp_ovf);
        logic exp_zero;
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
        #5;
        exp_zero = (exp_res == 32'h0);
        checks = checks + 1;
        if (result !== exp_res || ovf_flag !== exp_ovf || zero_flag !== exp_zero) begin
            failures = failures + 1;
            $display("FAIL %s: op=%h a=%h b=%h sh=%0d actual res=%h ovf=%b zero=%b expected res=%h ovf=%b zero=%b",
                     tag, op, a, b, sh, result, ovf_flag, zero_flag, exp_res, exp_ovf, exp_zero);
        end
    endtask

    // Signed add reference computed with 33-bit arithmetic
    function automatic logic add_ovf(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        w = {a[31], a} + {b[31], b};
        return w[32] ^ w[31];
    endfunction

    function automatic logic sub_ovf(input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        w = {a[31], a} - {b[31], b};
        return w[32] ^ w[31];
    endfunction

    task automatic test_idle_state;
        apply_and_check("R1 R9 all-zero inputs", 4'h0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic test_signed_add;
        logic [31:0] av [0:4] = '{32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678, 32'h80000000};
        logic [31:0] bv [0:4] = '{32'h00000001, 32'h80000000, 32'h00000001, 32'h11111111, 32'h7FFFFFFF};
        for (int i = 0; i < 5; i++) begin
            apply_and_check("R1 R2 add", 4'h0, av[i], bv[i], 5'd3, av[i] + bv[i], add_ovf(av[i], bv[i]));
            apply_and_check("R1 R2 addi", 4'h1, av[i], bv[i], 5'd0, av[i] + bv[i], add_ovf(av[i], bv[i]));
        end
        // explicit corner: overflow with all-zero result raises both flags
        apply_and_check("R2 R9 ovf with zero", 4'h0, 32'h80000000, 32'h80000000, 5'd0, 32'h0, 1'b1);
    endtask

    task automatic test_unsigned_wrap;
        apply_and_check("R3 addu wrap", 4'h3, 32'hFFFFFFFF, 32'h3, 5'd0, 32'h2, 1'b0);
        apply_and_check("R3 addu no trap", 4'h3, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h80000000, 1'b0);
        apply_and_check("R3 addiu no trap", 4'h4, 32'h80000000, 32'h80000000, 5'd0, 32'h0, 1'b0);
        apply_and_check("R3 R4 subu no trap", 4'h5, 32'h80000000, 32'h1, 5'd0, 32'h7FFFFFFF, 1'b0);
        apply_and_check("R3 R4 subu borrow", 4'h5, 32'h0, 32'h1, 5'd0, 32'hFFFFFFFF, 1'b0);
    endtask

    task automatic test_signed_sub;
        logic [31:0] av [0:4] = '{32'h80000000, 32'h00000000, 32'h00000005, 32'h7FFFFFFF, 32'hFFFFFFFE};
        logic [31:0] bv [0:4] = '{32'h00000001, 32'h80000000, 32'h00000005, 32'hFFFFFFFF, 32'h7FFFFFFF};
        for (int i = 0; i < 5; i++)
            apply_and_check("R4 R5 sub", 4'h2, av[i], bv[i], 5'd0, av[i] - bv[i], sub_ovf(av[i], bv[i]));
        // differing signs that do not overflow
        apply_and_check("R5 sub mixed no ovf", 4'h2, 32'hFFFFFFFF, 32'h00000001, 5'd0, 32'hFFFFFFFE, 1'b0);
    endtask

    task automatic test_shifts;
        apply_and_check("R6 sll by 2", 4'h6, 32'h00000002, 32'hDEADBEEF, 5'd2, 32'h00000008, 1'b0);
        apply_and_check("R6 sll by 31", 4'h6, 32'h00000003, 32'h0, 5'd31, 32'h80000000, 1'b0);
        apply_and_check("R6 R9 sll out", 4'h6, 32'h80000000, 32'h1, 5'd1, 32'h0, 1'b0);
        apply_and_check("R7 srl by 31", 4'h7, 32'h80000001, 32'hFFFFFFFF, 5'd31, 32'h1, 1'b0);
        apply_and_check("R7 srl by 4", 4'h7, 32'hF000000F, 32'h0, 5'd4, 32'h0F000000, 1'b0);
        apply_and_check("R8 sll by 0", 4'h6, 32'hA5A5A5A5, 32'h12345678, 5'd0, 32'hA5A5A5A5, 1'b0);
        apply_and_check("R8 srl by 0", 4'h7, 32'h5A5A5A5A, 32'h87654321, 5'd0, 32'h5A5A5A5A, 1'b0);
    endtask

    task automatic test_unused_ops;
        for (int op = 8; op < 16; op++)
            apply_and_check("R10 unused op", op[3:0], 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd7, 32'h0, 1'b0);
    endtask

    initial begin
        opnd_a = '0; opnd_b = '0; shamt = '0; op_sel = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_idle_state();
        test_signed_add();
        test_unsigned_wrap();
        test_signed_sub();
        test_shifts();
        test_unused_ops();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule